// File: doc/BRIEF.md
# Paged Register Bank with Serial Slave Port

This block puts four pages of sixty-four 16-bit registers behind a four-wire serial slave port. The serial clock idles low. The host drives a new bit on each rising edge and the block samples on the falling edge. MOSI and MISO move together, most significant bit first. A system clock that runs well above the serial clock samples all serial pins through a synchroniser.

A transaction starts when chip select falls. The first 16-bit word after that edge is a command. It carries a direction flag, a page number and a starting register address. Every word that follows while chip select stays low is data, and each data word steps the address pointer by one. The pointer does not wrap into the next page. Once it has passed the last register of the page, reads return all ones and writes are dropped. Pages above the implemented range behave the same way from the start of the transaction.

Top module: `spi_page_regs`

## Requirements
- R1: The serial clock idles low. The block samples MOSI on each falling serial clock edge, updates MISO after each rising edge, and moves words most significant bit first.
- R2: In the command word, bit 15 selects direction (1 read, 0 write), bits 14:11 give the page and bits 10:5 give the register address. Bits 4:0 have no effect.
- R3: Only the first full word after a chip-select falling edge is decoded as a command. Later words in the same low period are data, even when they look like commands. Serial clock activity while chip select is high has no effect.
- R4: A data word of a write is stored at the pointer only after all 16 bits have arrived. A word cut short by chip select rising changes no register.
- R5: After every complete data word, read or write, the pointer moves to the next address.
- R6: The pointer stops at address 63. Data written beyond it is discarded, and registers of other pages are untouched.
- R7: Every read word beyond address 63 of a page returns 0xFFFF.
- R8: Pages 4 to 15 are reserved. Reads there return 0xFFFF and writes there change no register.
- R9: MISO is 0 for the whole command word. On the first rising edge of a data word, MISO carries bit 15 of that word's read value.
- R10: After reset, every register reads 0 and MISO is 0.
- R11: Command 0x0800 writes from page 1 address 0, and command 0x8000 reads from page 0 address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
Two events can land in the same system clock cycle: a write that commits to address 63, and the pointer saturating at the page end. The same falling edge triggers both. The bench provokes this with write bursts that start a few registers below the end of a page and run past it. It then reads the tail of that page, which must show the stored words followed by 0xFFFF. It also reads address 0 of the following page, which must be unchanged. Random bursts whose start address is biased toward the page end repeat this case, and a model in the bench scores every word.

// File: rtl/spi_pr_pkg.sv
package spi_pr_pkg;

  // Transaction phase of the serial link.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2
  } link_state_e;

endpackage

// File: rtl/spi_pr_sync.sv
module spi_pr_sync #(
  parameter int          STAGES  = 2,
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);

  logic [N-1:0] chain_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= RST_VAL;
        else        chain_q[g] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= RST_VAL;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/spi_pr_serdes.sv
module spi_pr_serdes
  import spi_pr_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] tx_word,
  output link_state_e       state,
  output logic [CNT_W-1:0]  bit_idx,
  output logic              cmd_done,
  output logic              data_done,
  output logic [DATA_W-1:0] rx_word,
  output logic              miso
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  link_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              miso_q, miso_d;
  logic              sclk_d_q, cs_n_d_q;

  logic sclk_rise, sclk_fall, cs_rise, cs_fall, active, word_end;
  logic [DATA_W-1:0] rx_full;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_d_q;
    sclk_fall = ~sclk_s & sclk_d_q;
    cs_fall   = ~cs_n_s & cs_n_d_q;
    cs_rise   = cs_n_s & ~cs_n_d_q;
    active    = (state_q != ST_IDLE);
    word_end  = active && sclk_fall && !cs_rise && !cs_fall && (cnt_q == LAST_BIT);
    rx_full   = {rx_q[DATA_W-2:0], mosi_s};

    state_d = state_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    miso_d  = miso_q;

    if (cs_rise) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      tx_d    = '0;
      miso_d  = 1'b0;
    end else if (cs_fall) begin
      state_d = ST_CMD;
      cnt_d   = '0;
      tx_d    = '0;
      miso_d  = 1'b0;
    end else if (active) begin
      if (sclk_fall) begin
        rx_d  = rx_full;
        cnt_d = (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
        if ((cnt_q == LAST_BIT) && (state_q == ST_CMD)) state_d = ST_DATA;
      end
      if (sclk_rise) begin
        if (state_q == ST_DATA) begin
          if (cnt_q == '0) begin
            miso_d = tx_word[DATA_W-1];
            tx_d   = {tx_word[DATA_W-2:0], 1'b0};
          end else begin
            miso_d = tx_q[DATA_W-1];
            tx_d   = {tx_q[DATA_W-2:0], 1'b0};
          end
        end else begin
          miso_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cs_n_d_q <= 1'b1;
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      miso_q   <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      cs_n_d_q <= cs_n_s;
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      miso_q   <= miso_d;
    end
  end

  assign state     = state_q;
  assign bit_idx   = cnt_q;
  assign cmd_done  = word_end && (state_q == ST_CMD);
  assign data_done = word_end && (state_q == ST_DATA);
  assign rx_word   = rx_full;
  assign miso      = miso_q;

endmodule

// File: rtl/spi_pr_ctrl.sv
module spi_pr_ctrl #(
  parameter int DATA_W    = 16,
  parameter int PAGE_W    = 4,
  parameter int ADDR_W    = 6,
  parameter int NUM_PAGES = 4,
  localparam int PSEL_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_done,
  input  logic              data_done,
  input  logic [DATA_W-1:0] rx_word,
  input  logic [DATA_W-1:0] rd_data,
  output logic [PSEL_W-1:0] acc_page,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] tx_word,
  output logic              past_end
);

  localparam int DIR_BIT  = DATA_W - 1;
  localparam int PAGE_LSB = DIR_BIT - PAGE_W;
  localparam int ADDR_LSB = PAGE_LSB - ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  logic              dir_q, dir_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              end_q, end_d;
  logic              page_ok;

  always_comb begin
    page_ok = (int'(page_q) < NUM_PAGES);
    dir_d   = dir_q;
    page_d  = page_q;
    ptr_d   = ptr_q;
    end_d   = end_q;
    if (cmd_done) begin
      dir_d  = rx_word[DIR_BIT];
      page_d = rx_word[PAGE_LSB +: PAGE_W];
      ptr_d  = rx_word[ADDR_LSB +: ADDR_W];
      end_d  = 1'b0;
    end else if (data_done) begin
      if (ptr_q == LAST_ADDR) end_d = 1'b1;
      else                    ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      page_q <= '0;
      ptr_q  <= '0;
      end_q  <= 1'b0;
    end else begin
      dir_q  <= dir_d;
      page_q <= page_d;
      ptr_q  <= ptr_d;
      end_q  <= end_d;
    end
  end

  assign acc_page = page_q[PSEL_W-1:0];
  assign acc_addr = ptr_q;
  assign wr_en    = data_done && !dir_q && page_ok && !end_q;
  assign wr_data  = rx_word;
  assign tx_word  = (page_ok && !end_q) ? rd_data : '1;
  assign past_end = end_q;

endmodule

// File: rtl/spi_pr_regfile.sv
module spi_pr_regfile #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 6,
  parameter int NUM_PAGES = 4,
  localparam int PSEL_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int REGS     = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PSEL_W-1:0] page,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [NUM_PAGES-1:0][DATA_W-1:0] page_rd;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    logic [DATA_W-1:0] regs_q [REGS];
    logic              sel;

    assign sel = wr_en && (page == PSEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < REGS; i++) regs_q[i] <= '0;
      end else if (sel) begin
        regs_q[addr] <= wr_data;
      end
    end

    assign page_rd[g] = regs_q[addr];
  end

  assign rd_data = page_rd[page];

endmodule

// File: rtl/spi_page_regs.sv
module spi_page_regs
  import spi_pr_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PAGE_W      = 4,
  parameter int ADDR_W      = 6,
  parameter int NUM_PAGES   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PSEL_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int CNT_W      = $clog2(DATA_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);

  logic [2:0]        pins_s;
  link_state_e       link_st;
  logic [CNT_W-1:0]  bit_idx;
  logic              cmd_done, data_done, wr_en, past_end;
  logic [DATA_W-1:0] rx_word, tx_word, rd_data, wr_data;
  logic [PSEL_W-1:0] acc_page;
  logic [ADDR_W-1:0] acc_addr;

  spi_pr_sync #(
    .STAGES (SYNC_STAGES),
    .N      (3),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in({mosi, cs_n, sclk}),
    .sync_out(pins_s)
  );

  spi_pr_serdes #(.DATA_W(DATA_W)) u_serdes (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (pins_s[0]),
    .cs_n_s   (pins_s[1]),
    .mosi_s   (pins_s[2]),
    .tx_word  (tx_word),
    .state    (link_st),
    .bit_idx  (bit_idx),
    .cmd_done (cmd_done),
    .data_done(data_done),
    .rx_word  (rx_word),
    .miso     (miso)
  );

  spi_pr_ctrl #(
    .DATA_W   (DATA_W),
    .PAGE_W   (PAGE_W),
    .ADDR_W   (ADDR_W),
    .NUM_PAGES(NUM_PAGES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_done (cmd_done),
    .data_done(data_done),
    .rx_word  (rx_word),
    .rd_data  (rd_data),
    .acc_page (acc_page),
    .acc_addr (acc_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .tx_word  (tx_word),
    .past_end (past_end)
  );

  spi_pr_regfile #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NUM_PAGES(NUM_PAGES)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .page   (acc_page),
    .addr   (acc_addr),
    .wr_data(wr_data),
    .rd_data(rd_data)
  );

endmodule

// File: rtl/spi_page_regs_checker.sv
module spi_page_regs_checker
  import spi_pr_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input link_state_e       state,
  input logic [CNT_W-1:0]  cnt,
  input logic              miso,
  input logic              cmd_done,
  input logic              data_done,
  input logic              wr_en,
  input logic [ADDR_W-1:0] ptr,
  input logic              past_end
);

  // R9: nothing but zeros leaves the block while a command is shifting in
  assert_cmd_miso_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMD) |-> (miso == 1'b0));

  // R4: a register write happens only when a full data word has arrived
  assert_write_on_full_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (data_done && (state == ST_DATA)));

  // R5: a completed data word below the page end advances the pointer by one
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && !past_end && (ptr != '1)) |=> (ptr == $past(ptr) + 1'b1));

  // R6: once past the page end, the pointer stays put until a new command
  assert_end_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_end && !cmd_done) |=> (past_end && $stable(ptr)));

  // R3: with chip select high no bits are counted
  assert_idle_no_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (cnt == '0));

endmodule

bind spi_page_regs spi_page_regs_checker #(
  .CNT_W (CNT_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .state    (link_st),
  .cnt      (bit_idx),
  .miso     (miso),
  .cmd_done (cmd_done),
  .data_done(data_done),
  .wr_en    (wr_en),
  .ptr      (acc_addr),
  .past_end (past_end)
);

// File: tb/spi_page_regs_bench.sv
module spi_page_regs_bench;

  logic clk, rst_n, sclk, cs_n, mosi, miso;
  int   checks, errors;
  logic [15:0] model [4][64];
  logic [15:0] wbuf [16];
  bit   done_flag;

  spi_page_regs u_spi_page_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .sclk (sclk),
    .cs_n (cs_n),
    .mosi (mosi),
    .miso (miso)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cmd(input bit rd, input int page, input int addr,
                                         input logic [4:0] resv);
    return {rd, 4'(page), 6'(addr), resv};
  endfunction

  // Master: drive on rising edge, sample MISO just before the falling edge.
  task automatic xfer_bits(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx = '0;
    for (int i = 15; i > 15 - nbits; i--) begin
      sclk = 1'b1;
      mosi = tx[i];
      ticks(6);
      rx[i] = miso;
      sclk = 1'b0;
      ticks(6);
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    ticks(6);
  endtask

  task automatic cs_end();
    ticks(6);
    cs_n = 1'b1;
    ticks(6);
  endtask

  task automatic write_txn(input int page, input int addr, input int n, input logic [4:0] resv);
    logic [15:0] rx;
    int ptr = addr;
    bit past = 0;
    cs_begin();
    xfer_bits(mk_cmd(0, page, addr, resv), 16, rx);
    chk("R9", "miso during write command", rx, 16'h0000);
    for (int i = 0; i < n; i++) begin
      xfer_bits(wbuf[i], 16, rx);
      if (page < 4 && !past) model[page][ptr] = wbuf[i];
      if (ptr == 63) past = 1;
      else ptr++;
    end
    cs_end();
  endtask

  task automatic read_txn(input int page, input int addr, input int n, input string tag);
    logic [15:0] rx;
    logic [15:0] exp;
    int ptr = addr;
    bit past = 0;
    cs_begin();
    xfer_bits(mk_cmd(1, page, addr, 5'h00), 16, rx);
    chk("R9", "miso during read command", rx, 16'h0000);
    for (int i = 0; i < n; i++) begin
      xfer_bits(16'h0000, 16, rx);
      if (page >= 4) begin
        chk("R8", "reserved page read", rx, 16'hFFFF);
      end else if (past) begin
        chk("R7", "read past page end", rx, 16'hFFFF);
      end else begin
        exp = model[page][ptr];
        chk(tag, $sformatf("read p%0d a%0d", page, ptr), rx, exp);
      end
      if (ptr == 63) past = 1;
      else ptr++;
    end
    cs_end();
  endtask

  initial begin
    done_flag = 0;
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    checks = 0;
    errors = 0;
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 64; a++) model[p][a] = 16'h0000;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    sclk  = 1'b0;
    cs_n  = 1'b1;
    mosi  = 1'b0;
    ticks(5);
    rst_n = 1'b1;
    ticks(5);

    // R10: reset state
    chk("R10", "miso after reset", {15'h0, miso}, 16'h0000);
    read_txn(2, 10, 3, "R10");
    read_txn(3, 63, 1, "R10");

    // R11: example commands 0x0800 (write p1 a0) and 0x8000 (read p0 a0)
    chk("R11", "write command code", mk_cmd(0, 1, 0, 5'h00), 16'h0800);
    chk("R11", "read command code", mk_cmd(1, 0, 0, 5'h00), 16'h8000);
    wbuf[0] = 16'h1234;
    wbuf[1] = 16'hBEEF;
    write_txn(1, 0, 2, 5'h00);
    read_txn(0, 0, 2, "R11");
    read_txn(1, 0, 2, "R1");

    // R2: reserved command bits have no effect
    wbuf[0] = 16'hA5C3;
    wbuf[1] = 16'h0F0F;
    write_txn(3, 7, 2, 5'h1F);
    read_txn(3, 6, 4, "R2");

    // R3: serial clocking with chip select high is ignored
    xfer_bits(mk_cmd(0, 1, 0, 5'h00), 16, rx);
    xfer_bits(16'h0000, 16, rx);
    read_txn(1, 0, 1, "R3");

    // R3: a command-shaped second word is data
    wbuf[0] = 16'h8000;
    wbuf[1] = 16'hAAAA;
    write_txn(0, 20, 2, 5'h00);
    read_txn(0, 20, 2, "R3");

    // R4: word cut short by chip select rising is dropped
    cs_begin();
    xfer_bits(mk_cmd(0, 0, 20, 5'h00), 16, rx);
    xfer_bits(16'h5555, 9, rx);
    cs_end();
    read_txn(0, 20, 1, "R4");

    // R6/R7: burst crossing page end; commit at 63 and saturation coincide
    for (int i = 0; i < 4; i++) wbuf[i] = 16'(16'h7700 + i);
    write_txn(2, 62, 4, 5'h00);
    read_txn(2, 61, 5, "R6");
    read_txn(3, 0, 1, "R6");

    // R8: reserved page
    wbuf[0] = 16'h4242;
    wbuf[1] = 16'h4343;
    write_txn(5, 0, 2, 5'h00);
    read_txn(5, 0, 2, "R8");
    read_txn(1, 0, 1, "R8");

    // R5: random bursts
    for (int t = 0; t < 40; t++) begin
      int page = (($urandom % 8) == 0) ? 4 + int'($urandom % 12) : int'($urandom % 4);
      int addr = (($urandom % 3) == 0) ? 58 + int'($urandom % 6) : int'($urandom % 64);
      int n    = 1 + int'($urandom % 6);
      if ($urandom % 2) begin
        for (int i = 0; i < n; i++) wbuf[i] = 16'($urandom);
        write_txn(page, addr, n, 5'($urandom));
      end else begin
        read_txn(page, addr, n, "R5");
      end
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule